// File: doc/BRIEF.md
# Saturating Three-Wire Wiper Counter

This block is the digital control half of a 100-position trimmer. The trimmer is driven over three plain control lines: an active-low select, a direction line and an active-low step line. It also has a recall pulse that stands for a supply cycle of the trimmer. All three control lines are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and edges are detected on the synchronised levels.

While the block is selected, every falling step edge moves a 7-bit wiper position by one tap in the direction given by the direction line. The position stops at the end taps instead of wrapping. When select is released, the level of the step line decides the outcome. If step is high, the position is written to a storage register that models nonvolatile memory. If step is low, the position is simply kept.

A store holds a busy flag for a fixed number of cycles and then puts the block into standby. The recall pulse reloads the position from storage. The chip reset clears everything, storage included. Besides the tap index, the block drives a one-of-N tap select. All pins are plain control and status lines, so there is no valid/ready handshake.

Top module: `trim_wiper_ctrl`

## Requirements
- R1: Inputs `sel_n`, `dir_up` and `step_n` act only after two synchroniser flops plus one edge flop. Step edges that arrive while the block is not selected leave `tap_index` unchanged.
- R2: While selected, a falling edge on `step_n` increments `tap_index` when `dir_up`=1 and decrements it when `dir_up`=0. `dir_up` may change between steps within one selection.
- R3: `tap_index` is 7 bits wide and always lies in 0..NUM_TAPS-1 (0..99 by default).
- R4: Stepping up at NUM_TAPS-1, or down at 0, leaves `tap_index` unchanged. There is no wrap-around.
- R5: A rising edge on `sel_n` while selected with `step_n`=1 copies `tap_index` into storage and holds `store_busy`=1 for STORE_CYCLES clocks. A falling `sel_n` during that time is ignored, and the block stays deselected until `sel_n` rises and falls again.
- R6: A rising edge on `sel_n` while selected with `step_n`=0 deselects the block without storing. `store_busy` stays 0 and `tap_index` keeps its value.
- R7: `standby` goes to 1 when a store's busy period ends. It returns to 0 when a falling `sel_n` is accepted.
- R8: A one-cycle `recall_pulse` (synchronous, active high) loads `tap_index` from storage, deselects the block and clears `store_busy` and `standby`. Storage is kept across the pulse.
- R9: `tap_onehot` has exactly one bit set, at position `tap_index`.
- R10: `rst_n` low clears `tap_index`, the flags and storage. A recall with no store since reset therefore yields position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset; also clears storage |
| recall_pulse | input | 1 | Synchronous one-cycle pulse modelling a trimmer power-up recall |
| sel_n | input | 1 | Asynchronous active-low select |
| dir_up | input | 1 | Asynchronous direction: 1 counts up, 0 counts down |
| step_n | input | 1 | Asynchronous step line; the falling edge moves the wiper |
| tap_index | output | 7 | Current wiper position |
| tap_onehot | output | NUM_TAPS | One-hot tap select decoded from the position |
| store_busy | output | 1 | High while a store is in progress |
| standby | output | 1 | High from the end of a store until the next accepted select |

## Verification
The properties assume that `recall_pulse` is synchronous and lasts a single cycle. They also assume that `step_n` and `sel_n` never change within the same synchroniser window, so a step edge and a select edge are never seen in the same cycle. The stimulus holds every level for at least four clocks before the next change and issues recall only while the block is deselected. It reaches both end taps with extra steps, stores once, and deselects once with step low. It also drops select inside a busy window and applies the chip reset, so that recall from empty storage is exercised.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int DEF_TAPS = 100;
  localparam int DEF_STORE_CYCLES = 8;

  typedef enum logic [1:0] {
    LANE_SEL  = 2'd0,
    LANE_DIR  = 2'd1,
    LANE_STEP = 2'd2
  } lane_e;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/trim_sync_edge.sv
module trim_sync_edge #(
  parameter int W = 3,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  // two-flop synchroniser followed by a history flop, one lane per bit
  for (genvar g = 0; g < W; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= IDLE[g];
        sync_q[g] <= IDLE[g];
        prev_q[g] <= IDLE[g];
      end else begin
        meta_q[g] <= async_in[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign level[g] = sync_q[g];
    assign rise[g]  = sync_q[g] & ~prev_q[g];
    assign fall[g]  = ~sync_q[g] & prev_q[g];
  end
endmodule

// File: rtl/trim_wiper_count.sv
module trim_wiper_count #(
  parameter int NUM_TAPS = 100,
  localparam int IDX_W = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  input  logic             up,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_TAPS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_val;
    end else if (step) begin
      if (up && idx_q != TOP)
        idx_q <= idx_q + 1'b1;
      else if (!up && idx_q != '0)
        idx_q <= idx_q - 1'b1;
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/trim_store_ctrl.sv
module trim_store_ctrl #(
  parameter int NUM_TAPS = 100,
  parameter int STORE_CYCLES = 8,
  localparam int IDX_W = $clog2(NUM_TAPS),
  localparam int CNT_W = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall,
  input  logic             sel_fall,
  input  logic             sel_rise,
  input  logic             step_level,
  input  logic [IDX_W-1:0] idx,
  output logic             active,
  output logic [IDX_W-1:0] saved,
  output logic             busy,
  output logic             standby
);
  logic             active_q, busy_q, standby_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] saved_q;
  logic             do_store;

  assign do_store = active_q && sel_rise && step_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      busy_q    <= 1'b0;
      standby_q <= 1'b0;
      cnt_q     <= '0;
      saved_q   <= '0;
    end else if (recall) begin
      active_q  <= 1'b0;
      busy_q    <= 1'b0;
      standby_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q    <= 1'b0;
          standby_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (do_store) begin
        busy_q   <= 1'b1;
        cnt_q    <= CNT_W'(STORE_CYCLES - 1);
        saved_q  <= idx;
        active_q <= 1'b0;
      end else if (sel_rise) begin
        active_q <= 1'b0;
      end else if (sel_fall) begin
        active_q  <= 1'b1;
        standby_q <= 1'b0;
      end
    end
  end

  assign active  = active_q;
  assign saved   = saved_q;
  assign busy    = busy_q;
  assign standby = standby_q;
endmodule

// File: rtl/trim_tap_decode.sv
module trim_tap_decode #(
  parameter int NUM_TAPS = 100,
  localparam int IDX_W = $clog2(NUM_TAPS)
) (
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_TAPS-1:0] onehot
);
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign onehot[t] = (idx == IDX_W'(t));
  end
endmodule

// File: rtl/trim_wiper_ctrl.sv
module trim_wiper_ctrl
  import trim_pkg::*;
#(
  parameter int NUM_TAPS = DEF_TAPS,
  parameter int STORE_CYCLES = DEF_STORE_CYCLES,
  localparam int IDX_W = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                recall_pulse,
  input  logic                sel_n,
  input  logic                dir_up,
  input  logic                step_n,
  output logic [IDX_W-1:0]    tap_index,
  output logic [NUM_TAPS-1:0] tap_onehot,
  output logic                store_busy,
  output logic                standby
);
  localparam logic [NUM_LANES-1:0] IDLE_LVL = 3'b101;

  logic [NUM_LANES-1:0] raw, lvl, rise, fall;
  logic                 active;
  logic [IDX_W-1:0]     saved;

  assign raw[LANE_SEL]  = sel_n;
  assign raw[LANE_DIR]  = dir_up;
  assign raw[LANE_STEP] = step_n;

  trim_sync_edge #(.W(NUM_LANES), .IDLE(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw),
    .level(lvl), .rise(rise), .fall(fall)
  );

  trim_store_ctrl #(.NUM_TAPS(NUM_TAPS), .STORE_CYCLES(STORE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .recall(recall_pulse),
    .sel_fall(fall[LANE_SEL]), .sel_rise(rise[LANE_SEL]),
    .step_level(lvl[LANE_STEP]), .idx(tap_index),
    .active(active), .saved(saved), .busy(store_busy), .standby(standby)
  );

  trim_wiper_count #(.NUM_TAPS(NUM_TAPS)) u_count (
    .clk(clk), .rst_n(rst_n), .load(recall_pulse), .load_val(saved),
    .step(active & fall[LANE_STEP]), .up(lvl[LANE_DIR]), .idx(tap_index)
  );

  trim_tap_decode #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .idx(tap_index), .onehot(tap_onehot)
  );
endmodule

// File: rtl/trim_wiper_chk.sv
module trim_wiper_chk #(
  parameter int NUM_TAPS = 100,
  localparam int IDX_W = $clog2(NUM_TAPS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                recall_pulse,
  input logic [IDX_W-1:0]    tap_index,
  input logic [NUM_TAPS-1:0] tap_onehot,
  input logic                store_busy,
  input logic                standby
);
  localparam logic [IDX_W:0] TOP = (IDX_W+1)'(NUM_TAPS - 1);

  logic [IDX_W:0] idx_x;
  assign idx_x = {1'b0, tap_index};

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_x <= TOP); // R3

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_onehot) == 1 && tap_onehot[tap_index]); // R9

  AST_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(recall_pulse) && idx_x != $past(idx_x))
      |-> (idx_x == $past(idx_x) + 1'b1 || idx_x + 1'b1 == $past(idx_x))); // R2

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(recall_pulse) && $past(idx_x) == TOP) |-> idx_x != '0); // R4

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(store_busy) && !$past(recall_pulse)) |-> $stable(tap_index)); // R5

  AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(store_busy) && !$past(recall_pulse)) |-> standby); // R7

  AST_RECALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    recall_pulse |=> (!store_busy && !standby)); // R8
endmodule

bind trim_wiper_ctrl trim_wiper_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .recall_pulse(recall_pulse),
  .tap_index(tap_index), .tap_onehot(tap_onehot),
  .store_busy(store_busy), .standby(standby)
);

// File: tb/trim_wiper_ctrl_test.sv
`timescale 1ns/1ps
module trim_wiper_ctrl_test;
  localparam int NT = 100;
  localparam int SC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recall_pulse = 1'b0;
  logic sel_n = 1'b1;
  logic dir_up = 1'b0;
  logic step_n = 1'b1;
  logic [6:0]    tap_index;
  logic [NT-1:0] tap_onehot;
  logic          store_busy, standby;

  always #2 clk = ~clk;

  trim_wiper_ctrl #(.NUM_TAPS(NT), .STORE_CYCLES(SC)) uut (
    .clk(clk), .rst_n(rst_n), .recall_pulse(recall_pulse),
    .sel_n(sel_n), .dir_up(dir_up), .step_n(step_n),
    .tap_index(tap_index), .tap_onehot(tap_onehot),
    .store_busy(store_busy), .standby(standby)
  );

  typedef struct {
    string    req;
    int       idx;
    bit       busy;
    bit       sb;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // scoreboard monitor: pops expected items, compares at the sampling point
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [NT-1:0] oh;
        e = exp_q.pop_front();
        oh = '0;
        oh[e.idx] = 1'b1;
        n_vec++;
        if (tap_index !== 7'(e.idx) || tap_onehot !== oh ||
            store_busy !== e.busy || standby !== e.sb) begin
          n_bad++;
          $display("FAIL %s: idx=%0d busy=%0b sb=%0b onehot_ok=%0b exp idx=%0d busy=%0b sb=%0b",
                   e.req, tap_index, store_busy, standby, tap_onehot === oh,
                   e.idx, e.busy, e.sb);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string r, input int i, input bit b, input bit s);
    exp_t e;
    e.req = r; e.idx = i; e.busy = b; e.sb = s;
    exp_q.push_back(e);
    -> chk_ev;
    #0;
  endtask

  task automatic step_once();
    step_n = 1'b0; cyc(4);
    step_n = 1'b1; cyc(4);
  endtask

  task automatic recall();
    recall_pulse = 1'b1; cyc(1);
    recall_pulse = 1'b0; cyc(2);
  endtask

  initial begin
    cyc(3);
    expect_now("R10 reset", 0, 0, 0);
    rst_n = 1'b1; cyc(3);
    expect_now("R9 decode at reset", 0, 0, 0);

    // R1: steps without select
    dir_up = 1'b1; cyc(4);
    for (int k = 0; k < 3; k++) step_once();
    expect_now("R1 deselected steps ignored", 0, 0, 0);

    // R2: up then down within one selection
    sel_n = 1'b0; cyc(5);
    for (int k = 0; k < 5; k++) step_once();
    expect_now("R2 up five", 5, 0, 0);
    dir_up = 1'b0; cyc(4);
    for (int k = 0; k < 2; k++) step_once();
    expect_now("R2 down two", 3, 0, 0);

    // R4: saturate at both ends
    for (int k = 0; k < 5; k++) step_once();
    expect_now("R4 floor at 0", 0, 0, 0);
    dir_up = 1'b1; cyc(4);
    for (int k = 0; k < 105; k++) step_once();
    expect_now("R4 ceiling at 99 (R3)", 99, 0, 0);

    // R6: deselect with step low (the step fall counts first)
    dir_up = 1'b0; cyc(4);
    step_n = 1'b0; cyc(5);
    sel_n = 1'b1; cyc(8);
    expect_now("R6 no store, position kept", 98, 0, 0);
    step_n = 1'b1; cyc(5);
    recall();
    expect_now("R10 recall of empty storage (R8)", 0, 0, 0);

    // R5/R7: store path
    sel_n = 1'b0; dir_up = 1'b1; cyc(5);
    for (int k = 0; k < 7; k++) step_once();
    expect_now("R2 up seven", 7, 0, 0);
    sel_n = 1'b1; cyc(4);
    expect_now("R5 busy during store", 7, 1, 0);
    sel_n = 1'b0; cyc(12);
    expect_now("R7 standby after store", 7, 0, 1);
    for (int k = 0; k < 3; k++) step_once();
    expect_now("R5 select during busy ignored", 7, 0, 1);
    sel_n = 1'b1; cyc(6);
    expect_now("R5 inactive release does not store", 7, 0, 1);
    sel_n = 1'b0; cyc(6);
    expect_now("R7 standby left on select", 7, 0, 0);
    for (int k = 0; k < 3; k++) step_once();
    step_n = 1'b0; cyc(5);
    sel_n = 1'b1; cyc(8);
    expect_now("R6 release with step low", 11, 0, 0);
    step_n = 1'b1; cyc(5);
    recall();
    expect_now("R8 recall of stored 7", 7, 0, 0);

    // R10: reset clears storage
    rst_n = 1'b0; cyc(2);
    rst_n = 1'b1; cyc(3);
    recall();
    expect_now("R10 storage cleared by reset", 0, 0, 0);

    cyc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule